// File: doc/BRIEF.md
# Programmable Fractional-N Divider Counter

This block counts cycles of a fast input clock. It emits one output pulse every N input cycles. The count N is chosen again for every output period, so a sigma-delta modulator can dither N from period to period and make the average ratio fractional. Each period's N is the sum of a fixed unsigned base word and a small signed offset from the modulator. The sum is clamped to the supported span of 56 to 255.

Inside, the count follows a pulse-swallow arrangement. A dual-modulus prescaler divides by 2 or 3. A program counter and a swallow counter decide which modulus each prescaler cycle uses. On the last input cycle of a period the block raises its output pulse and a request strobe to the modulator. On the clock edge that ends that cycle it takes in the next ratio.

Top module: `fnd_divider`

## Requirements
- R1: The ratio for a period is the unsigned `base_word_i` plus the two's-complement `sdm_offset_i`, both sampled on the clock edge that ends the terminal cycle of the previous period. It is shown on `ratio_o` for the whole of the period.
- R2: A sum below 56 becomes 56 and a sum above 255 becomes 255. `sat_o` is 1 for every cycle of a period whose ratio was clamped, and 0 otherwise.
- R3: The number of input clock cycles from one output pulse to the next equals the ratio shown on `ratio_o` during that period.
- R4: `div_pulse_o` is high for exactly one input cycle, which is the last cycle of each period.
- R5: `sdm_req_o` is high in exactly the cycles in which `div_pulse_o` is high.
- R6: Changes of `base_word_i` or `sdm_offset_i` before the terminal cycle of a period alter neither that period's length nor `ratio_o`.
- R7: `rst` is synchronous and active high. While it is high the block loads `base_word_i` with a zero offset, clamped as in R2, and holds `div_pulse_o` low. The first pulse comes on the ratio-th cycle after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| base_word_i | input | BASE_W | Unsigned integer part of the ratio |
| sdm_offset_i | input | OFS_W | Signed modulator offset added to the base |
| div_pulse_o | output | 1 | Divided output, one cycle wide at period end |
| sdm_req_o | output | 1 | Asks the modulator for its next offset |
| ratio_o | output | RATIO_W | Ratio in force for the current period |
| sat_o | output | 1 | Current ratio was clamped |

## Verification
The base word is swept across both clamp edges and through the middle of the range, and at each base every offset from -8 to +7 is applied. This separates correct signed extension and clamping from wrap-around, and also covers bases that lie out of range on their own. A second sweep steps the base through every ratio from 56 to 255 with a zero offset. This exercises odd and even ratios, and with them the swallow and no-swallow paths. In every period the inputs carry wrong values for the first few cycles and are corrected later, which shows that only the values present at the terminal cycle count. A reset applied in mid-period with an out-of-range base and a nonzero offset shows that reset uses a zero offset and that clamping also applies on reset.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

  typedef enum logic {
    PS_LOW  = 1'b0,
    PS_HIGH = 1'b1
  } ps_mode_e;

  function automatic int unsigned ps_modulus(input ps_mode_e mode, input int unsigned low_div);
    return (mode == PS_HIGH) ? low_div + 1 : low_div;
  endfunction

endpackage

// File: rtl/fnd_ratio_sum.sv
module fnd_ratio_sum #(
  parameter int BASE_W    = 8,
  parameter int OFS_W     = 4,
  parameter int RATIO_W   = 8,
  parameter int RATIO_MIN = 56,
  parameter int RATIO_MAX = 255
) (
  input  logic [BASE_W-1:0]  base_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               clamped_o
);
  localparam int SUM_W = ((BASE_W > RATIO_W) ? BASE_W : RATIO_W) + 2;
  localparam logic signed [SUM_W-1:0] LO = SUM_W'(RATIO_MIN);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'(RATIO_MAX);

  logic signed [SUM_W-1:0] base_ext;
  logic signed [SUM_W-1:0] ofs_ext;
  logic signed [SUM_W-1:0] sum;

  always_comb begin
    base_ext = $signed(SUM_W'(base_i));
    ofs_ext  = $signed({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
    sum      = base_ext + ofs_ext;
    if (sum < LO) begin
      ratio_o   = RATIO_W'(RATIO_MIN);
      clamped_o = 1'b1;
    end else if (sum > HI) begin
      ratio_o   = RATIO_W'(RATIO_MAX);
      clamped_o = 1'b1;
    end else begin
      ratio_o   = sum[RATIO_W-1:0];
      clamped_o = 1'b0;
    end
  end
endmodule

// File: rtl/fnd_split.sv
module fnd_split #(
  parameter int RATIO_W = 8,
  parameter int PRE_DIV = 2,
  parameter int PCNT_W  = 8,
  parameter int SCNT_W  = 1
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [PCNT_W-1:0]  prog_o,
  output logic [SCNT_W-1:0]  swallow_o
);
  localparam bool_pow2 = ((PRE_DIV & (PRE_DIV - 1)) == 0);
  localparam int SHIFT = $clog2(PRE_DIV);

  generate
    if (bool_pow2) begin : g_shift
      always_comb begin
        prog_o    = PCNT_W'(ratio_i >> SHIFT);
        swallow_o = SCNT_W'(ratio_i & RATIO_W'(PRE_DIV - 1));
      end
    end else begin : g_divide
      always_comb begin
        prog_o    = PCNT_W'(ratio_i / RATIO_W'(PRE_DIV));
        swallow_o = SCNT_W'(ratio_i % RATIO_W'(PRE_DIV));
      end
    end
  endgenerate
endmodule

// File: rtl/fnd_swallow_ctr.sv
module fnd_swallow_ctr #(
  parameter int PCNT_W = 8,
  parameter int SCNT_W = 1
) (
  input  logic              clk,
  input  logic              load_i,
  input  logic [PCNT_W-1:0] prog_load_i,
  input  logic [SCNT_W-1:0] swallow_load_i,
  input  logic              ps_end_i,
  output logic              hi_next_o,
  output logic              last_next_o
);
  logic [PCNT_W-1:0] prog_q, prog_d;
  logic [SCNT_W-1:0] swal_q, swal_d;

  always_comb begin
    prog_d = prog_q;
    swal_d = swal_q;
    if (load_i) begin
      prog_d = prog_load_i;
      swal_d = swallow_load_i;
    end else if (ps_end_i) begin
      prog_d = prog_q - PCNT_W'(1);
      if (swal_q != '0) swal_d = swal_q - SCNT_W'(1);
    end
    hi_next_o   = (swal_d != '0);
    last_next_o = (prog_d == PCNT_W'(1));
  end

  always_ff @(posedge clk) begin
    prog_q <= prog_d;
    swal_q <= swal_d;
  end
endmodule

// File: rtl/fnd_prescaler.sv
module fnd_prescaler
  import fnd_pkg::*;
#(
  parameter int PRE_DIV = 2
) (
  input  logic clk,
  input  logic load_i,
  input  logic hi_next_i,
  output logic end_o,
  output logic end_next_o
);
  localparam int CNT_W = $clog2(PRE_DIV + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  ps_mode_e         mode_next;

  always_comb begin
    mode_next = hi_next_i ? PS_HIGH : PS_LOW;
    if (load_i || cnt_q == '0)
      cnt_d = CNT_W'(ps_modulus(mode_next, PRE_DIV) - 1);
    else
      cnt_d = cnt_q - CNT_W'(1);
    end_next_o = (cnt_d == '0);
  end

  assign end_o = (cnt_q == '0);

  always_ff @(posedge clk) cnt_q <= cnt_d;
endmodule

// File: rtl/fnd_divider.sv
module fnd_divider #(
  parameter int BASE_W    = 8,
  parameter int OFS_W     = 4,
  parameter int RATIO_W   = 8,
  parameter int RATIO_MIN = 56,
  parameter int RATIO_MAX = 255,
  parameter int PRE_DIV   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BASE_W-1:0]  base_word_i,
  input  logic [OFS_W-1:0]   sdm_offset_i,
  output logic               div_pulse_o,
  output logic               sdm_req_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               sat_o
);
  localparam int PCNT_W = $clog2(RATIO_MAX / PRE_DIV + 1);
  localparam int SCNT_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;

  logic [OFS_W-1:0]   ofs_eff;
  logic [RATIO_W-1:0] ratio_new;
  logic               clamp_new;
  logic [PCNT_W-1:0]  prog_new;
  logic [SCNT_W-1:0]  swal_new;
  logic               load;
  logic               hi_next, last_next, ps_end, ps_end_next;
  logic               pulse_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               sat_q;

  assign ofs_eff = rst ? '0 : sdm_offset_i;
  assign load    = rst | pulse_q;

  fnd_ratio_sum #(
    .BASE_W(BASE_W), .OFS_W(OFS_W), .RATIO_W(RATIO_W),
    .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
  ) sum_i (
    .base_i(base_word_i), .ofs_i(ofs_eff),
    .ratio_o(ratio_new), .clamped_o(clamp_new)
  );

  fnd_split #(
    .RATIO_W(RATIO_W), .PRE_DIV(PRE_DIV), .PCNT_W(PCNT_W), .SCNT_W(SCNT_W)
  ) split_i (
    .ratio_i(ratio_new), .prog_o(prog_new), .swallow_o(swal_new)
  );

  fnd_swallow_ctr #(.PCNT_W(PCNT_W), .SCNT_W(SCNT_W)) swc_i (
    .clk(clk), .load_i(load), .prog_load_i(prog_new),
    .swallow_load_i(swal_new), .ps_end_i(ps_end),
    .hi_next_o(hi_next), .last_next_o(last_next)
  );

  fnd_prescaler #(.PRE_DIV(PRE_DIV)) pre_i (
    .clk(clk), .load_i(load), .hi_next_i(hi_next),
    .end_o(ps_end), .end_next_o(ps_end_next)
  );

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= ps_end_next & last_next;
    if (load) begin
      ratio_q <= ratio_new;
      sat_q   <= clamp_new;
    end
  end

  assign div_pulse_o = pulse_q;
  assign sdm_req_o   = pulse_q;
  assign ratio_o     = ratio_q;
  assign sat_o       = sat_q;
endmodule

// File: rtl/fnd_divider_chk.sv
module fnd_divider_chk #(
  parameter int RATIO_W   = 8,
  parameter int RATIO_MIN = 56,
  parameter int RATIO_MAX = 255
) (
  input logic               clk,
  input logic               rst,
  input logic               div_pulse_o,
  input logic               sdm_req_o,
  input logic [RATIO_W-1:0] ratio_o
);
  logic [RATIO_W:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst || div_pulse_o) cyc_q <= (RATIO_W+1)'(1);
    else                    cyc_q <= cyc_q + (RATIO_W+1)'(1);
  end

  // R5
  req_matches_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sdm_req_o == div_pulse_o);

  // R4
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse_o |=> !div_pulse_o);

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!div_pulse_o) |=> $stable(ratio_o));

  // R2
  ratio_range_chk: assert property (@(posedge clk) disable iff (rst)
    (ratio_o >= RATIO_W'(RATIO_MIN)) && (ratio_o <= RATIO_W'(RATIO_MAX)));

  // R3
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse_o |-> (cyc_q == {1'b0, ratio_o}));

  // R3
  no_early_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!div_pulse_o) |-> (cyc_q < {1'b0, ratio_o}));
endmodule

bind fnd_divider fnd_divider_chk #(
  .RATIO_W(RATIO_W), .RATIO_MIN(RATIO_MIN), .RATIO_MAX(RATIO_MAX)
) chk_i (
  .clk(clk), .rst(rst), .div_pulse_o(div_pulse_o),
  .sdm_req_o(sdm_req_o), .ratio_o(ratio_o)
);

// File: tb/fnd_divider_tb_top.sv
module fnd_divider_tb_top;
  logic             clk = 1'b0;
  logic             rst;
  logic [7:0]       base;
  logic [3:0]       ofs;
  logic             pulse, req, sat;
  logic [7:0]       ratio;

  int checks = 0;
  int errors = 0;
  int cnt;
  int exp_cur;
  bit exp_sat;
  bit hung = 1'b0;

  always #4 clk = ~clk;

  fnd_divider dut_i (
    .clk(clk), .rst(rst), .base_word_i(base), .sdm_offset_i(ofs),
    .div_pulse_o(pulse), .sdm_req_o(req), .ratio_o(ratio), .sat_o(sat)
  );

  task automatic chk(input bit ok, input string req_tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, expv);
    end
  endtask

  task automatic model(input int b, input int o, output int r, output bit s);
    int t;
    t = b + o;
    s = (t < 56) || (t > 255);
    r = (t < 56) ? 56 : ((t > 255) ? 255 : t);
  endtask

  // Called at the negedge of the first cycle of a period.
  task automatic run_period(input int b, input int o);
    bit ended;
    chk(ratio == 8'(exp_cur), "R1 ratio_o", int'(ratio), exp_cur);
    chk(sat == exp_sat, "R2 sat_o", int'(sat), int'(exp_sat));
    base = 8'(255 - b);
    ofs  = 4'(-o - 1);
    ended = 1'b0;
    while (!ended && !hung) begin
      @(negedge clk);
      cnt++;
      if (cnt == 5) begin
        base = 8'(b);
        ofs  = 4'(o);
      end
      if (req != pulse) chk(1'b0, "R5 req", int'(req), int'(pulse));
      if (pulse) begin
        chk(cnt == exp_cur, "R3 period", cnt, exp_cur);
        chk(ratio == 8'(exp_cur), "R6 ratio_o held", int'(ratio), exp_cur);
        ended = 1'b1;
      end else if (cnt > 300) begin
        chk(1'b0, "R3 watchdog", cnt, exp_cur);
        hung = 1'b1;
      end
    end
    model(b, o, exp_cur, exp_sat);
    @(negedge clk);
    chk(!pulse, "R4 pulse width", int'(pulse), 0);
    cnt = 1;
  endtask

  initial begin
    int bases[10] = '{0, 50, 56, 57, 100, 127, 128, 200, 250, 255};
    rst  = 1'b1;
    base = 8'd100;
    ofs  = 4'd5;
    repeat (3) @(negedge clk);
    chk(!pulse, "R7 pulse low in reset", int'(pulse), 0);
    rst = 1'b0;
    cnt = 1;
    exp_cur = 100;
    exp_sat = 1'b0;
    chk(ratio == 8'd100, "R7 zero offset at reset", int'(ratio), 100);

    foreach (bases[i]) begin
      for (int o = -8; o <= 7; o++) begin
        if (!hung) run_period(bases[i], o);
      end
    end
    for (int b = 56; b <= 255; b++) begin
      if (!hung) run_period(b, 0);
    end

    // R7: reset mid-period with an out-of-range base
    repeat (17) @(negedge clk);
    rst  = 1'b1;
    base = 8'd20;
    ofs  = 4'd3;
    repeat (2) @(negedge clk);
    chk(!pulse, "R7 pulse low in reset", int'(pulse), 0);
    chk(ratio == 8'd56, "R7 reset clamp", int'(ratio), 56);
    chk(sat == 1'b1, "R7 reset sat", int'(sat), 1);
    rst = 1'b0;
    cnt = 1;
    exp_cur = 56;
    exp_sat = 1'b1;
    if (!hung) run_period(100, 0);
    if (!hung) run_period(100, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule